// File: doc/BRIEF.md
# End-of-Interrupt Re-arm Controller with Storm Throttle

This block sits beside the redirection table of a level-triggered interrupt router. It takes an end-of-interrupt strobe that carries a vector. It walks the table one pin per cycle and looks for level-mode entries whose vector matches. For each one whose remote IRR flag is still set, it asks the table owner to clear that flag. It then decides whether the pin should be serviced again at once.

A pin that is unmasked and still pending right after its acknowledge counts as a back-to-back re-assertion. Each pin keeps a counter of these. While the counter stays below a programmable limit, every re-assertion raises an immediate service-request pulse. When the counter reaches the limit, it returns to zero and no immediate request is made. Instead, a shared countdown timer is armed, and it raises one service-request pulse after a programmable number of cycles. This lets a storming source make slow progress without flooding the router.

Any write to a pin's table entry resets that pin's counter. The block does not generate interrupt messages. It only produces the clear requests and the service pulses.

Top module: `eoi_rearm_ctrl`

## Requirements
- R1: An entry is acted on only when its vector equals the latched strobe vector and its trigger bit `ent_level` is 1. Edge-mode entries and entries with another vector get no clear request, no service pulse and no counter change.
- R2: A matching entry whose remote IRR flag is 0 is skipped. It gets no clear request, no service pulse, and its counter keeps its value.
- R3: Pin k is examined in scan cycle k. For a matching entry with remote IRR set, bit k of `rirr_clr` is high for exactly one cycle, in the cycle after the strobe is accepted plus k. At most one bit of `rirr_clr` is ever high.
- R4: After a clear, if the entry is unmasked (`ent_mask`=0) and still pending (`pend`=1), the pin's counter increments. If the new value is below LIMIT, `svc_req` pulses in the same cycle as the clear request.
- R5: After a clear, a masked or no-longer-pending entry resets its counter to 0 and produces no service pulse.
- R6: When an increment would make the counter equal LIMIT, the counter returns to 0 and no immediate pulse is given. The delay timer is armed instead, and `svc_req` pulses exactly DELAY cycles after the clear request of that pin.
- R7: A deferral arms the timer only when the timer is idle, or when its remaining time exceeds DELAY. A deferral that arrives while the timer is running leaves the pending expiry in place, and each expiry gives exactly one pulse.
- R8: A pulse on `tbl_wr` resets the counter of pin `tbl_wr_pin`. If the scan updates the same pin in the same cycle, the write wins.
- R9: A strobe is accepted only while `busy` is low. `busy` then stays high for exactly NPINS cycles. Strobes that arrive while `busy` is high are ignored.
- R10: After reset, `busy`, `rirr_clr` and `svc_req` are 0, all counters are 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector carried by the strobe |
| ent_vector | input | NPINS*VEC_W | Vector field of every entry, pin k at bits k*VEC_W upward |
| ent_level | input | NPINS | Trigger mode per pin, 1 = level |
| ent_mask | input | NPINS | Mask bit per pin, 1 = masked |
| ent_rirr | input | NPINS | Remote IRR flag per pin |
| pend | input | NPINS | Pending request bit per pin |
| tbl_wr | input | 1 | A half of an entry was written |
| tbl_wr_pin | input | PW | Pin whose entry was written |
| busy | output | 1 | Scan in progress |
| rirr_clr | output | NPINS | One-cycle remote-IRR clear request per pin |
| svc_req | output | 1 | One-cycle service-request pulse |

## Verification
The bench builds the block with NPINS=8, LIMIT=4 and DELAY=20. A small limit lets a storm trip within four acknowledges. A short delay lets the deferred pulse arrive within a few scans. Two pins that trip in one scan arm the timer about two cycles apart, so the case of a deferral arriving while the timer is already running is reached in a directed test, and it is reached again under random stimulus.

// File: rtl/eoi_rearm_pkg.sv
`timescale 1ns/1ps
package eoi_rearm_pkg;

  // Counter value after one scan step: bump increments, else restart at 0;
  // reaching the limit also wraps to 0.
  function automatic int unsigned storm_next(int unsigned cnt, int unsigned limit, logic bump);
    if (!bump) return 0;
    return (cnt + 1 >= limit) ? 0 : cnt + 1;
  endfunction

  // A bump that reaches the limit trips the throttle.
  function automatic logic storm_trips(int unsigned cnt, int unsigned limit, logic bump);
    return bump && (cnt + 1 >= limit);
  endfunction

  // Timer may be (re)loaded only when idle or when a reload would fire sooner.
  function automatic logic arm_allowed(int unsigned remaining, int unsigned delay);
    return (remaining == 0) || (remaining > delay);
  endfunction

endpackage

// File: rtl/eoi_scan.sv
`timescale 1ns/1ps
module eoi_scan #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  parameter int PW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] start_vec,
  output logic             busy,
  output logic [PW-1:0]    idx,
  output logic [VEC_W-1:0] vec_q
);
  localparam logic [PW-1:0] LAST = PW'(NPINS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      vec_q <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      vec_q <= start_vec;
    end
  end
endmodule

// File: rtl/storm_cnt_bank.sv
`timescale 1ns/1ps
module storm_cnt_bank
  import eoi_rearm_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int LIMIT = 10000,
  parameter int CNT_W = $clog2(LIMIT + 1),
  parameter int PW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [PW-1:0] step_idx,
  input  logic          step_bump,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  output logic          trip
);
  logic [CNT_W-1:0] cnt_q [NPINS];
  logic [CNT_W-1:0] cur_cnt;

  assign cur_cnt = cnt_q[step_idx];
  assign trip    = step_en && storm_trips(32'(cur_cnt), LIMIT, step_bump);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
      end else if (wr_en && (wr_idx == PW'(i))) begin
        cnt_q[i] <= '0;
      end else if (step_en && (step_idx == PW'(i))) begin
        cnt_q[i] <= CNT_W'(storm_next(32'(cnt_q[i]), LIMIT, step_bump));
      end
    end
  end
endmodule

// File: rtl/rearm_timer.sv
`timescale 1ns/1ps
module rearm_timer
  import eoi_rearm_pkg::*;
#(
  parameter int DELAY = 2000000,
  parameter int TW    = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire,
  output logic running
);
  logic [TW-1:0] t_q, t_dec, t_n;

  always_comb begin
    t_dec = (t_q != '0) ? t_q - 1'b1 : '0;
    t_n   = (arm && arm_allowed(32'(t_dec), DELAY)) ? TW'(DELAY) : t_dec;
  end

  assign expire  = (t_q == TW'(1));
  assign running = (t_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_n;
  end
endmodule

// File: rtl/eoi_rearm_ctrl.sv
`timescale 1ns/1ps
module eoi_rearm_ctrl #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  parameter int LIMIT = 10000,
  parameter int DELAY = 2000000,
  parameter int PW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic [NPINS*VEC_W-1:0] ent_vector,
  input  logic [NPINS-1:0]       ent_level,
  input  logic [NPINS-1:0]       ent_mask,
  input  logic [NPINS-1:0]       ent_rirr,
  input  logic [NPINS-1:0]       pend,
  input  logic                   tbl_wr,
  input  logic [PW-1:0]          tbl_wr_pin,
  output logic                   busy,
  output logic [NPINS-1:0]       rirr_clr,
  output logic                   svc_req
);
  // Named internal events, visible to the bound checker.
  logic [PW-1:0]    scan_idx;
  logic [VEC_W-1:0] scan_vec;
  logic [VEC_W-1:0] cur_vec;
  logic             hit_w, bump_w, trip_w, imm_w, defer_w;
  logic             expire_w, tmr_busy_w;
  logic [NPINS-1:0] rirr_clr_q;
  logic             svc_q;

  eoi_scan #(.NPINS(NPINS), .VEC_W(VEC_W), .PW(PW)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(eoi_valid), .start_vec(eoi_vector),
    .busy(busy), .idx(scan_idx), .vec_q(scan_vec)
  );

  assign cur_vec = ent_vector[scan_idx*VEC_W +: VEC_W];
  assign hit_w   = busy && (cur_vec == scan_vec) && ent_level[scan_idx] && ent_rirr[scan_idx];
  assign bump_w  = hit_w && !ent_mask[scan_idx] && pend[scan_idx];

  storm_cnt_bank #(.NPINS(NPINS), .LIMIT(LIMIT), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(hit_w), .step_idx(scan_idx),
    .step_bump(bump_w), .wr_en(tbl_wr), .wr_idx(tbl_wr_pin), .trip(trip_w)
  );

  assign defer_w = trip_w;
  assign imm_w   = bump_w && !trip_w;

  rearm_timer #(.DELAY(DELAY)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(defer_w), .expire(expire_w), .running(tmr_busy_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_clr_q <= '0;
      svc_q      <= 1'b0;
    end else begin
      rirr_clr_q <= hit_w ? (NPINS'(1) << scan_idx) : '0;
      svc_q      <= imm_w || expire_w;
    end
  end

  assign rirr_clr = rirr_clr_q;
  assign svc_req  = svc_q;
endmodule

// File: rtl/eoi_rearm_chk.sv
`timescale 1ns/1ps
module eoi_rearm_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoi_valid,
  input logic             busy,
  input logic [NPINS-1:0] rirr_clr,
  input logic             svc_req,
  input logic             expire_w,
  input logic             defer_w,
  input logic             tmr_busy_w
);
  logic [15:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R3: never more than one clear request at a time
  assert_clr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_clr));

  // R9: a clear request only follows a scanning cycle
  assert_clr_in_scan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr != '0) |-> $past(busy));

  // R9: a scan never outlasts NPINS cycles
  assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < 16'(NPINS)));

  // R9: a scan starts only after a strobe
  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eoi_valid));

  // R4: a pulse not from the timer comes from a scanning cycle
  assert_svc_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && !$past(expire_w)) |-> $past(busy));

  // R6: a deferral leaves the timer running
  assert_defer_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_w |=> tmr_busy_w);

  // R6: a deferral without a coincident expiry gives no pulse next cycle
  assert_defer_no_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_w && !expire_w) |=> !svc_req);
endmodule

bind eoi_rearm_ctrl eoi_rearm_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .busy(busy),
  .rirr_clr(rirr_clr), .svc_req(svc_req), .expire_w(expire_w),
  .defer_w(defer_w), .tmr_busy_w(tmr_busy_w)
);

// File: tb/eoi_rearm_ctrl_bench.sv
`timescale 1ns/1ps
module eoi_rearm_ctrl_bench;
  localparam int N   = 8;
  localparam int VW  = 8;
  localparam int LIM = 4;
  localparam int DLY = 20;
  localparam int PW  = 3;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            eoi_valid = 0;
  logic [VW-1:0]   eoi_vector = '0;
  logic [N*VW-1:0] ent_vec = '0;
  logic [N-1:0]    lvl = '0, msk = '0, rirr = '0, pend = '0;
  logic            wr = 0;
  logic [PW-1:0]   wr_pin = '0;
  logic            busy, svc_req;
  logic [N-1:0]    rirr_clr;

  always #2.5 clk = ~clk;

  eoi_rearm_ctrl #(.NPINS(N), .VEC_W(VW), .LIMIT(LIM), .DELAY(DLY)) u_eoi_rearm_ctrl (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .ent_vector(ent_vec), .ent_level(lvl), .ent_mask(msk), .ent_rirr(rirr),
    .pend(pend), .tbl_wr(wr), .tbl_wr_pin(wr_pin),
    .busy(busy), .rirr_clr(rirr_clr), .svc_req(svc_req)
  );

  int tests = 0, fails = 0;
  string cur_req = "R10";

  // Reference state kept from the requirements
  int m_cnt [N];
  int m_t = 0, m_idx = 0;
  bit m_busy = 0;
  logic [VW-1:0] m_vec = '0;

  function automatic logic [VW-1:0] vec_of(int p);
    return ent_vec[p*VW +: VW];
  endfunction

  task automatic check(bit eb, logic [N-1:0] ec, bit es);
    tests++;
    if (busy !== eb || rirr_clr !== ec || svc_req !== es) begin
      fails++;
      $display("FAIL %s: busy/clr/svc got %b/%b/%b exp %b/%b/%b",
               cur_req, busy, rirr_clr, svc_req, eb, ec, es);
    end
  endtask

  // One clock: predict, advance, compare, then act as the table owner.
  task automatic tick();
    logic [N-1:0] e_clr;
    bit e_svc, dfr;
    int p;
    e_clr = '0; e_svc = 0; dfr = 0;
    if (m_busy) begin
      p = m_idx;
      if (vec_of(p) == m_vec && lvl[p] && rirr[p]) begin
        e_clr[p] = 1'b1;
        if (!msk[p] && pend[p]) begin
          if (m_cnt[p] + 1 == LIM) begin m_cnt[p] = 0; dfr = 1; end
          else begin m_cnt[p] = m_cnt[p] + 1; e_svc = 1; end
        end else m_cnt[p] = 0;
      end
    end
    if (wr) m_cnt[wr_pin] = 0;
    if (m_t == 1) e_svc = 1;
    m_t = (m_t > 0) ? m_t - 1 : 0;
    if (dfr && m_t == 0) m_t = DLY;
    if (m_busy) begin
      m_idx = m_idx + 1;
      if (m_idx == N) begin m_busy = 0; m_idx = 0; end
    end else if (eoi_valid) begin
      m_busy = 1; m_idx = 0; m_vec = eoi_vector;
    end
    @(posedge clk);
    @(negedge clk);
    check(m_busy, e_clr, e_svc);
    rirr = rirr & ~e_clr;
    eoi_valid = 0;
    wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_eoi(logic [VW-1:0] v);
    eoi_valid = 1; eoi_vector = v;
    tick();
    idle(N);
  endtask

  task automatic clear_all();
    for (int p = 0; p < N; p++) ent_vec[p*VW +: VW] = VW'(8'h10 + p);
    lvl = '1; msk = '0; rirr = '0; pend = '0;
  endtask

  task automatic set_pin(int p, logic [VW-1:0] v, bit l, bit m, bit r, bit pd);
    ent_vec[p*VW +: VW] = v; lvl[p] = l; msk[p] = m; rirr[p] = r; pend[p] = pd;
  endtask

  initial begin
    for (int p = 0; p < N; p++) m_cnt[p] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: idle outputs straight after reset
    cur_req = "R10";
    check(0, '0, 0);
    idle(2);
    clear_all();

    // R1: edge-mode or other-vector entries are left alone
    cur_req = "R1";
    set_pin(5, 8'h41, 0, 0, 1, 1);
    set_pin(6, 8'h42, 1, 0, 1, 1);
    run_eoi(8'h41);
    clear_all();

    // R4: matching unmasked pending level entry re-serviced at once
    cur_req = "R4";
    set_pin(2, 8'h41, 1, 0, 1, 1);
    set_pin(5, 8'h41, 0, 0, 1, 1);
    run_eoi(8'h41);
    clear_all();

    // R3: two matching pins cleared in pin order, one cycle each
    cur_req = "R3";
    set_pin(0, 8'h33, 1, 1, 1, 1);
    set_pin(7, 8'h33, 1, 0, 1, 1);
    run_eoi(8'h33);
    clear_all();

    // R5: not pending -> cleared, no service, counter reset
    cur_req = "R5";
    set_pin(7, 8'h33, 1, 0, 1, 0);
    run_eoi(8'h33);
    clear_all();

    // R6: fourth back-to-back re-assertion defers by DELAY
    cur_req = "R6";
    for (int k = 0; k < LIM; k++) begin
      set_pin(4, 8'h50, 1, 0, 1, 1);
      run_eoi(8'h50);
    end
    idle(DLY + 2);

    // R2: a skipped entry keeps its count, so the next bump trips
    cur_req = "R2";
    for (int k = 0; k < LIM - 1; k++) begin
      set_pin(4, 8'h50, 1, 0, 1, 1);
      run_eoi(8'h50);
    end
    set_pin(4, 8'h50, 1, 0, 0, 1);
    run_eoi(8'h50);
    set_pin(4, 8'h50, 1, 0, 1, 1);
    run_eoi(8'h50);
    idle(DLY + 2);

    // R8: a table write restarts the count
    cur_req = "R8";
    for (int k = 0; k < LIM - 1; k++) begin
      set_pin(4, 8'h50, 1, 0, 1, 1);
      run_eoi(8'h50);
    end
    wr = 1; wr_pin = 3'd4;
    tick();
    set_pin(4, 8'h50, 1, 0, 1, 1);
    run_eoi(8'h50);
    clear_all();

    // R7: two pins trip in one scan, only one deferred pulse
    cur_req = "R7";
    for (int k = 0; k < LIM; k++) begin
      set_pin(1, 8'h60, 1, 0, 1, 1);
      set_pin(3, 8'h60, 1, 0, 1, 1);
      run_eoi(8'h60);
    end
    idle(DLY + 2);
    clear_all();

    // R9: a strobe during a scan is ignored
    cur_req = "R9";
    set_pin(6, 8'h22, 1, 0, 1, 1);
    set_pin(2, 8'h23, 1, 0, 1, 1);
    eoi_valid = 1; eoi_vector = 8'h23;
    tick();
    idle(3);
    eoi_valid = 1; eoi_vector = 8'h22;
    tick();
    idle(N);
    clear_all();

    // Random mix, checked cycle by cycle against the reference
    cur_req = "R6";
    for (int it = 0; it < 60; it++) begin
      for (int p = 0; p < N; p++)
        set_pin(p, VW'(8'h70 + ($urandom % 3)), 1'($urandom % 4 != 0),
                1'($urandom % 5 == 0), 1'($urandom % 3 != 0), 1'($urandom % 5 != 0));
      eoi_valid = 1; eoi_vector = VW'(8'h70 + ($urandom % 3));
      tick();
      for (int c = 0; c < N + int'($urandom % 4); c++) begin
        if ($urandom % 8 == 0) begin wr = 1; wr_pin = PW'($urandom); end
        if ($urandom % 6 == 0) begin eoi_valid = 1; eoi_vector = VW'(8'h70 + ($urandom % 3)); end
        tick();
      end
    end
    idle(DLY + N + 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule